// File: doc/BRIEF.md
# Dual-Bank Keyboard Controller Host Register Interface

This block is the register window that a PC host sees into a laptop keyboard controller. The host uses an 8-bit bidirectional bus with active-low chip select, read and write strobes, and two address lines. Through this bus it writes data or command bytes and reads back output data or a status byte. A local CPU uses a simple synchronous port on the other side. It picks up what the host wrote, places reply bytes for the host, and sets a small configuration register.

There are two identical register banks. The primary bank is always present. The auxiliary bank is meant for power-management traffic and is selected by host address bit 1, but only while its enable bit in the configuration register is set. With that bit clear, address bit 1 is ignored and the block acts as a single-bank interface.

The configuration register also drives the gate-A20 output and the active-low host reset output directly. An output-buffer-full interrupt tells the host that a reply byte is waiting.

The host strobes are brought into the clock domain through a synchronizer of `SYNC_STAGES` flops. The register actions they cause land a few clocks after a strobe starts. The read data path on the bus is combinational from the strobes, so it needs no clock.

Top module: `kbd_host_if`

## Requirements
- R1: After reset, both banks have every status flag clear, `obf_irq` is 0, `gate_a20` is 0, `host_rst_n` is 1 and the configuration register reads 0.
- R2: A host write with address bit 0 low stores the bus byte as the selected bank's input byte and sets that bank's input-full flag (IBF). The command/data flag is cleared, and the local CPU reads the byte back at its data address.
- R3: A host write with address bit 0 high stores the byte, sets IBF and sets the command/data flag (CD) to 1.
- R4: A local CPU read of a bank's data address (`cpu_addr` 0 for the primary bank, 1 for the auxiliary bank) clears that bank's IBF.
- R5: A local CPU write to a bank's data address loads that bank's output byte and sets its output-full flag (OBF). A host read with address bit 0 low returns the output byte and clears OBF.
- R6: A host read with address bit 0 high returns the status byte: OBF in bit 0, IBF in bit 1, CD in bit 3, all other bits 0. This read changes no state.
- R7: While configuration bit 0 is clear, host address bit 1 is ignored: every host access reaches the primary bank and the auxiliary bank's flags are untouched.
- R8: While configuration bit 0 is set, host address bit 1 high selects the auxiliary bank. `obf_irq` is high while primary OBF is set, or while auxiliary OBF is set and the auxiliary bank is enabled.
- R9: Configuration register layout, written and read at `cpu_addr` 2, occupying bits 2:0 with the upper bits reading 0:
  - bit 0 enables the auxiliary bank;
  - bit 1 drives `gate_a20`;
  - bit 2 set drives `host_rst_n` low.
- R10: The block drives `host_data` only while `host_cs_n` and `host_rd_n` are both low; otherwise the bus is high impedance.
- R11: A local CPU read of `cpu_addr` 3 returns the primary bank's status nibble in bits 3:0 and the auxiliary bank's status nibble in bits 7:4, using the R6 bit layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_data | inout | 8 | Host bidirectional data bus |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 2 | Bit 0: data/command or data/status; bit 1: bank select |
| cpu_wr_en | input | 1 | Local CPU write enable, one access per cycle |
| cpu_rd_en | input | 1 | Local CPU read enable, one access per cycle |
| cpu_addr | input | 2 | Local register select (0, 1 bank data; 2 config; 3 status) |
| cpu_wdata | input | 8 | Local CPU write data |
| cpu_rdata | output | 8 | Local CPU read data, combinational |
| obf_irq | output | 1 | Output-buffer-full interrupt to host, active high |
| gate_a20 | output | 1 | Gate-A20 control output |
| host_rst_n | output | 1 | Host reset output, active low |

## Verification
The hardest case is a host access with address bit 1 high while the auxiliary bank is disabled. Reaching it needs a reply byte already pending in the auxiliary bank before that bank is switched on. The bench therefore writes a reply byte into the auxiliary bank while it is disabled and checks that the interrupt stays low. It also checks that a host status read at the auxiliary address shows the primary bank. It then enables the bank and confirms that the interrupt rises only at that moment and that the pending byte is delivered.

// File: rtl/kbd_host_pkg.sv
package kbd_host_pkg;
    localparam int BYTE_W = 8;
    localparam int NBANK  = 2;
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CD  = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] in_byte;
        logic [BYTE_W-1:0] out_byte;
        logic              ibf;
        logic              obf;
        logic              cd;
    } bank_t;

    typedef struct packed {
        logic rst_assert;
        logic a20;
        logic aux_en;
    } cfg_t;

    function automatic logic [BYTE_W-1:0] status_of(bank_t b);
        logic [BYTE_W-1:0] s;
        s         = '0;
        s[ST_OBF] = b.obf;
        s[ST_IBF] = b.ibf;
        s[ST_CD]  = b.cd;
        return s;
    endfunction
endpackage

// File: rtl/kbd_strobe_sync.sv
module kbd_strobe_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] start_pulse
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] stage_d [DEPTH];
    logic [W-1:0] stage_q [DEPTH];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign start_pulse = stage_q[STAGES-1] & ~stage_q[STAGES];
endmodule

// File: rtl/kbd_bank.sv
module kbd_bank
    import kbd_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_cd,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_rd_data,
    input  logic              cpu_rd_in,
    input  logic              cpu_wr_out,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output bank_t             state
);
    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (cpu_rd_in) bank_d.ibf = 1'b0;
        if (host_wr) begin
            bank_d.in_byte = host_wdata;
            bank_d.ibf     = 1'b1;
            bank_d.cd      = host_cd;
        end
        if (host_rd_data) bank_d.obf = 1'b0;
        if (cpu_wr_out) begin
            bank_d.out_byte = cpu_wdata;
            bank_d.obf      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign state = bank_q;
endmodule

// File: rtl/kbd_host_if.sv
module kbd_host_if
    import kbd_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    inout  wire  [BYTE_W-1:0] host_data,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [1:0]        host_addr,
    input  logic              cpu_wr_en,
    input  logic              cpu_rd_en,
    input  logic [1:0]        cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              obf_irq,
    output logic              gate_a20,
    output logic              host_rst_n
);
    localparam int CFG_W = $bits(cfg_t);
    localparam logic [1:0] CPU_CFG = 2'd2;
    localparam logic [1:0] CPU_ST  = 2'd3;

    logic [1:0] strobe_raw, strobe_pulse;
    logic       host_wr_pulse, host_rd_pulse;
    logic       host_rd_act;
    logic       host_bank;
    cfg_t       cfg_d, cfg_q;
    bank_t      bank_st [NBANK];
    logic [NBANK-1:0] bank_ibf;
    logic [BYTE_W-1:0] host_rdata;

    assign host_rd_act = !host_cs_n && !host_rd_n;
    assign strobe_raw  = {host_rd_act, !host_cs_n && !host_wr_n};

    kbd_strobe_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (strobe_raw),
        .start_pulse(strobe_pulse)
    );

    assign host_wr_pulse = strobe_pulse[0];
    assign host_rd_pulse = strobe_pulse[1];
    assign host_bank     = cfg_q.aux_en & host_addr[1];

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            logic sel;
            assign sel = (host_bank == 1'(b));
            kbd_bank i_bank (
                .clk         (clk),
                .rst_n       (rst_n),
                .host_wr     (host_wr_pulse && sel),
                .host_cd     (host_addr[0]),
                .host_wdata  (host_data),
                .host_rd_data(host_rd_pulse && sel && !host_addr[0]),
                .cpu_rd_in   (cpu_rd_en && cpu_addr == 2'(b)),
                .cpu_wr_out  (cpu_wr_en && cpu_addr == 2'(b)),
                .cpu_wdata   (cpu_wdata),
                .state       (bank_st[b])
            );
            assign bank_ibf[b] = bank_st[b].ibf;
        end
    endgenerate

    always_comb begin
        cfg_d = cfg_q;
        if (cpu_wr_en && cpu_addr == CPU_CFG) cfg_d = cfg_t'(cpu_wdata[CFG_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        host_rdata = host_addr[0] ? status_of(bank_st[host_bank])
                                  : bank_st[host_bank].out_byte;
    end

    assign host_data = host_rd_act ? host_rdata : {BYTE_W{1'bz}};

    always_comb begin
        logic [BYTE_W-1:0] s0, s1;
        s0 = status_of(bank_st[0]);
        s1 = status_of(bank_st[1]);
        case (cpu_addr)
            2'd0:    cpu_rdata = bank_st[0].in_byte;
            2'd1:    cpu_rdata = bank_st[1].in_byte;
            CPU_CFG: cpu_rdata = BYTE_W'(cfg_q);
            CPU_ST:  cpu_rdata = {s1[3:0], s0[3:0]};
            default: cpu_rdata = '0;
        endcase
    end

    assign obf_irq    = bank_st[0].obf | (cfg_q.aux_en & bank_st[1].obf);
    assign gate_a20   = cfg_q.a20;
    assign host_rst_n = ~cfg_q.rst_assert;
endmodule

// File: rtl/kbd_host_if_chk.sv
module kbd_host_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_wr_en,
    input logic       cpu_rd_en,
    input logic [1:0] cpu_addr,
    input logic [7:0] cpu_wdata,
    input logic       obf_irq,
    input logic       gate_a20,
    input logic       host_rst_n,
    input logic       wr_pulse,
    input logic [1:0] host_addr,
    input logic       aux_en,
    input logic [1:0] ibf
);
    a_r2_host_write_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !(aux_en && host_addr[1])) |=> ibf[0]);

    a_r4_cpu_read_clears_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_en && cpu_addr == 2'd0 && !wr_pulse) |=> !ibf[0]);

    a_r5_cpu_write_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && cpu_addr == 2'd0) |=> obf_irq);

    a_r8_irq_rises_on_cpu_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(obf_irq) |-> $past(cpu_wr_en));

    a_r7_aux_ibf_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !aux_en && !(cpu_rd_en && cpu_addr == 2'd1)) |=> $stable(ibf[1]));

    a_r9_config_drives_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && cpu_addr == 2'd2) |=>
            (gate_a20 == $past(cpu_wdata[1]) && host_rst_n == !$past(cpu_wdata[2])));
endmodule

bind kbd_host_if kbd_host_if_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr_en (cpu_wr_en),
    .cpu_rd_en (cpu_rd_en),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .obf_irq   (obf_irq),
    .gate_a20  (gate_a20),
    .host_rst_n(host_rst_n),
    .wr_pulse  (host_wr_pulse),
    .host_addr (host_addr),
    .aux_en    (cfg_q.aux_en),
    .ibf       (bank_ibf)
);

// File: tb/test_kbd_host_if.sv
module test_kbd_host_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [1:0] host_addr = '0;
    logic       cpu_wr_en = 1'b0, cpu_rd_en = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       obf_irq, gate_a20, host_rst_n;
    logic [7:0] tb_drv = '0;
    logic       tb_oe = 1'b0;
    wire  [7:0] host_data;
    int total = 0, bad = 0;

    assign host_data = tb_oe ? tb_drv : 8'bz;

    always #2 clk = ~clk;

    kbd_host_if i_kbd_host_if (
        .clk(clk), .rst_n(rst_n), .host_data(host_data),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_addr(host_addr), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .obf_irq(obf_irq), .gate_a20(gate_a20), .host_rst_n(host_rst_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; tb_drv = d; tb_oe = 1'b1;
        host_cs_n = 1'b0; host_wr_n = 1'b0;
        wait_neg(5);
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        wait_neg(1);
        tb_oe = 1'b0;
        wait_neg(3);
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_cs_n = 1'b0; host_rd_n = 1'b0;
        wait_neg(5);
        d = host_data;
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        wait_neg(4);
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr_en = 1'b1;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd_en = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd_en = 1'b0;
    endtask

    task automatic cpu_peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 obf_irq", {7'b0, obf_irq}, 8'h00);
        chk("R1 gate_a20", {7'b0, gate_a20}, 8'h00);
        chk("R1 host_rst_n", {7'b0, host_rst_n}, 8'h01);
        chk("R10 bus idle", host_data, 8'hzz);
        cpu_peek(2'd3, v); chk("R1 status", v, 8'h00);
        cpu_peek(2'd2, v); chk("R1 config", v, 8'h00);
    endtask

    task automatic t_data_write;
        logic [7:0] v;
        host_write(2'b00, 8'h5A);
        host_read(2'b01, v); chk("R6 host status after data write", v, 8'h02);
        host_read(2'b01, v); chk("R6 status read has no side effect", v, 8'h02);
        cpu_peek(2'd3, v);   chk("R11 cpu status nibble", v, 8'h02);
        cpu_read(2'd0, v);   chk("R2 cpu reads host byte", v, 8'h5A);
        cpu_peek(2'd3, v);   chk("R4 ibf cleared by cpu read", v, 8'h00);
        chk("R10 bus idle after reads", host_data, 8'hzz);
    endtask

    task automatic t_command_write;
        logic [7:0] v;
        host_write(2'b01, 8'hD1);
        host_read(2'b01, v); chk("R3 command sets CD", v, 8'h0A);
        cpu_read(2'd0, v);   chk("R3 command byte", v, 8'hD1);
        host_read(2'b01, v); chk("R4 ibf clear CD kept", v, 8'h08);
    endtask

    task automatic t_reply;
        logic [7:0] v;
        cpu_write(2'd0, 8'h33);
        @(negedge clk);
        chk("R5 obf_irq set", {7'b0, obf_irq}, 8'h01);
        host_read(2'b01, v); chk("R5 status shows OBF", v, 8'h09);
        host_read(2'b00, v); chk("R5 host reads reply", v, 8'h33);
        chk("R5 obf_irq cleared", {7'b0, obf_irq}, 8'h00);
        host_read(2'b01, v); chk("R5 OBF cleared", v, 8'h08);
    endtask

    task automatic t_aux_disabled;
        logic [7:0] v;
        host_write(2'b10, 8'h77);
        cpu_peek(2'd3, v);   chk("R7 A1 ignored goes to primary", v, 8'h02);
        cpu_read(2'd0, v);   chk("R7 primary got byte", v, 8'h77);
        cpu_write(2'd1, 8'h44);
        @(negedge clk);
        chk("R8 aux OBF masked while disabled", {7'b0, obf_irq}, 8'h00);
        host_read(2'b11, v); chk("R7 status at A1 shows primary", v, 8'h00);
    endtask

    task automatic t_aux_enabled;
        logic [7:0] v;
        cpu_write(2'd2, 8'h01);
        @(negedge clk);
        chk("R8 irq on enable with pending aux", {7'b0, obf_irq}, 8'h01);
        host_read(2'b11, v); chk("R8 aux status", v, 8'h01);
        host_read(2'b10, v); chk("R8 aux reply", v, 8'h44);
        chk("R8 irq cleared", {7'b0, obf_irq}, 8'h00);
        host_write(2'b11, 8'h99);
        cpu_peek(2'd3, v);   chk("R11 aux status nibble", v, 8'hA0);
        cpu_read(2'd1, v);   chk("R8 aux input byte", v, 8'h99);
        cpu_peek(2'd3, v);   chk("R4 aux ibf cleared", v, 8'h80);
        host_write(2'b00, 8'h12);
        cpu_peek(2'd3, v);   chk("R8 primary still at A1 low", v, 8'h82);
        cpu_read(2'd0, v);   chk("R8 primary byte", v, 8'h12);
    endtask

    task automatic t_config;
        logic [7:0] v;
        cpu_write(2'd2, 8'h07);
        @(negedge clk);
        chk("R9 gate_a20 high", {7'b0, gate_a20}, 8'h01);
        chk("R9 host reset asserted", {7'b0, host_rst_n}, 8'h00);
        cpu_peek(2'd2, v); chk("R9 config readback", v, 8'h07);
        cpu_write(2'd2, 8'hF8);
        @(negedge clk);
        chk("R9 gate_a20 low", {7'b0, gate_a20}, 8'h00);
        chk("R9 host reset released", {7'b0, host_rst_n}, 8'h01);
        cpu_peek(2'd2, v); chk("R9 upper bits read zero", v, 8'h00);
    endtask

    initial begin
        #50000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);
        t_reset();
        t_data_write();
        t_command_write();
        t_reply();
        t_aux_disabled();
        t_aux_enabled();
        t_config();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule